// File: doc/BRIEF.md
# Bicolor Status LED Controller

This block drives six two-colour (blue and red) indicator LEDs: one front status LED and a row of drive-bay LEDs, five by default. A host programs it through a narrow parallel bus. The bus has a 3-bit address, a 3-bit data word and one enable strobe. The strobe and both fields are brought into the clock domain through two-flop synchronizers. The rising edge of the synchronized strobe commits the data word into the addressed 3-bit register.

Each LED runs a colour pattern chosen by its mode register. The patterns are steady colours, timed blinks, blue/red alternations, and for bay LEDs a mode that follows that drive's activity input. The pattern output is then dimmed by a brightness PWM. The front LED has its own brightness register. All bay LEDs share one brightness register. Pattern time is built from whole steps of a shared step tick, nominally 0.5 s. The tick comes from a clock divider whose length is a parameter, so a bench can use a short step.

Top module: `bicolor_led_ctrl`

## Requirements
- R1: Address map: 0 = front mode, 1 = front brightness, 2 = shared bay brightness, 3+k = mode of bay LED k (k = 0..4). A register takes the data word on the rising edge of the synchronized strobe, with address and data held stable around that edge.
- R2: A write changes only the addressed register. Every other LED keeps its output pattern.
- R3: After reset all registers are 0, and every blue and red output stays low until a write is made.
- R4: Brightness PWM: a frame is 8 slots of SLOT_CLKS cycles. An LED colour may be lit only in slots whose index (0..7) is below the brightness value. Brightness 0 keeps both colours dark.
- R5: Front modes, with one step = STEP_CLKS cycles and a 12-step repeat: 0 dark; 1 blue always; 2 red always; 3 blue for 2 steps then dark for 2; 4 red for 2 steps then dark for 2.
- R6: Front modes 5 to 7: 5 is blue for 5 steps then red for 1; 6 is blue for 2 steps then red for 2; 7 is blue for 1 step then dark for 5.
- R7: Bay modes 0 and 2 to 6 behave as the front modes of the same number. Bay mode 7 is blue always.
- R8: Bay mode 1 shows blue while that bay's activity input is idle. Activity blanks the LED, which stays dark for at least HOLD_CLKS cycles after the activity input falls. Red is never lit in this mode, and other bays are not affected.
- R9: Writing a mode register restarts that LED's pattern at step 0, even when the value written equals the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_data | input | 3 | Write data |
| bus_en | input | 1 | Write strobe; its rising edge commits the write |
| bay_act | input | 5 | Per-bay activity, active high, asynchronous |
| front_blue | output | 1 | Front LED blue drive |
| front_red | output | 1 | Front LED red drive |
| bay_blue | output | 5 | Bay LED blue drives |
| bay_red | output | 5 | Bay LED red drives |

## Verification
The hardest case to reach is the pattern restart. Rewriting a mode with the value it already holds changes nothing visible unless the LED happens to be in a dark part of its pattern. The stimulus therefore watches the front output until it has stayed dark for several PWM frames, which puts it inside the off half of a blink. Only then does it repeat the write, and it expects a full window of lit PWM slots. All other patterns are compared by counting lit cycles over one full 12-step period. That count does not depend on where the window starts, so every mode and brightness pair can be swept and compared to simple products.

// File: rtl/bicolor_led_pkg.sv
package bicolor_led_pkg;

    localparam int VAL_W   = 3;
    localparam int SLOT_W  = 3;   // 8 PWM slots per frame
    localparam int PHASES  = 12;  // common repeat of 2 s and 3 s patterns, in steps
    localparam int PHASE_W = 4;

    typedef logic [VAL_W-1:0] val_t;

    localparam val_t M_DARK    = 3'd0;
    localparam val_t M_ALT1    = 3'd1; // front: steady blue, bay: activity
    localparam val_t M_RED     = 3'd2;
    localparam val_t M_BLINK_B = 3'd3;
    localparam val_t M_BLINK_R = 3'd4;
    localparam val_t M_B5_R1   = 3'd5;
    localparam val_t M_B2_R2   = 3'd6;
    localparam val_t M_ALT7    = 3'd7; // front: short blue flash, bay: steady blue

    localparam int REG_FRONT_MODE = 0;
    localparam int REG_FRONT_LVL  = 1;
    localparam int REG_BAY_LVL    = 2;
    localparam int REG_BAY_BASE   = 3;

endpackage

// File: rtl/led_strobe_bus.sv
module led_strobe_bus
    import bicolor_led_pkg::*;
#(
    parameter int AW   = 3,
    parameter int NREG = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               bus_addr,
    input  logic [VAL_W-1:0]            bus_data,
    input  logic                        bus_en,
    output logic [NREG-1:0][VAL_W-1:0]  regs_o,
    output logic [NREG-1:0]             wr_o
);

    typedef struct packed {
        logic [AW-1:0]              a1;
        logic [AW-1:0]              a2;
        logic [VAL_W-1:0]           d1;
        logic [VAL_W-1:0]           d2;
        logic                       e1;
        logic                       e2;
        logic                       e3;
        logic [NREG-1:0][VAL_W-1:0] regs;
    } bus_st_t;

    bus_st_t s_d, s_q;
    logic    commit;

    always_comb begin
        s_d    = s_q;
        s_d.a1 = bus_addr;
        s_d.a2 = s_q.a1;
        s_d.d1 = bus_data;
        s_d.d2 = s_q.d1;
        s_d.e1 = bus_en;
        s_d.e2 = s_q.e1;
        s_d.e3 = s_q.e2;
        commit = s_q.e2 & ~s_q.e3;
        wr_o   = '0;
        if (commit && (int'(s_q.a2) < NREG)) begin
            wr_o[s_q.a2] = 1'b1;
        end
        for (int i = 0; i < NREG; i++) begin
            if (wr_o[i]) begin
                s_d.regs[i] = s_q.d2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs_o = s_q.regs;

    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_o));

    for (genvar g = 0; g < NREG; g++) begin : g_keep
        a_r2_untouched_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_o[g] |=> $stable(regs_o[g]));
    end

endmodule

// File: rtl/led_timebase.sv
module led_timebase
    import bicolor_led_pkg::*;
#(
    parameter int STEP_CLKS = 25_000_000,
    parameter int SLOT_CLKS = 6250
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              step_tick,
    output logic [SLOT_W-1:0] slot_o
);

    localparam int DW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam int SW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    typedef struct packed {
        logic [DW-1:0]     div;
        logic [SW-1:0]     sdiv;
        logic [SLOT_W-1:0] slot;
        logic              tick;
    } tb_st_t;

    tb_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = (s_q.div == DW'(STEP_CLKS - 1));
        s_d.div  = s_d.tick ? '0 : s_q.div + 1'b1;
        if (s_q.sdiv == SW'(SLOT_CLKS - 1)) begin
            s_d.sdiv = '0;
            s_d.slot = s_q.slot + 1'b1;
        end else begin
            s_d.sdiv = s_q.sdiv + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_tick = s_q.tick;
    assign slot_o    = s_q.slot;

    if (STEP_CLKS > 1) begin : g_tick_chk
        a_r5_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            step_tick |=> !step_tick);
    end

endmodule

// File: rtl/led_channel.sv
module led_channel
    import bicolor_led_pkg::*;
#(
    parameter bit BAY       = 1'b0,
    parameter int HOLD_CLKS = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  mode,
    input  logic [VAL_W-1:0]  level,
    input  logic              mode_wr,
    input  logic              step_tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              act,
    output logic              blue_o,
    output logic              red_o
);

    localparam int HW = $clog2(HOLD_CLKS + 1);

    typedef struct packed {
        logic               a1;
        logic               a2;
        logic [HW-1:0]      hold;
        logic [PHASE_W-1:0] phase;
        logic               blue;
        logic               red;
    } ch_st_t;

    ch_st_t             s_d, s_q;
    logic               busy, pat_b, pat_r, gate, first_half;
    logic [PHASE_W-1:0] p6;

    always_comb begin
        s_d    = s_q;
        s_d.a1 = act;
        s_d.a2 = s_q.a1;
        busy   = s_q.a2 | (s_q.hold != '0);
        if (s_q.a2) begin
            s_d.hold = HW'(HOLD_CLKS);
        end else if (s_q.hold != '0) begin
            s_d.hold = s_q.hold - 1'b1;
        end

        if (mode_wr) begin
            s_d.phase = '0;
        end else if (step_tick) begin
            s_d.phase = (s_q.phase == PHASE_W'(PHASES - 1)) ? '0 : s_q.phase + 1'b1;
        end

        p6         = (s_q.phase >= PHASE_W'(6)) ? s_q.phase - PHASE_W'(6) : s_q.phase;
        first_half = ~s_q.phase[1];
        pat_b      = 1'b0;
        pat_r      = 1'b0;
        case (mode)
            M_ALT1:    pat_b = BAY ? ~busy : 1'b1;
            M_RED:     pat_r = 1'b1;
            M_BLINK_B: pat_b = first_half;
            M_BLINK_R: pat_r = first_half;
            M_B5_R1: begin
                pat_b = (p6 != PHASE_W'(5));
                pat_r = (p6 == PHASE_W'(5));
            end
            M_B2_R2: begin
                pat_b = first_half;
                pat_r = ~first_half;
            end
            M_ALT7:    pat_b = BAY ? 1'b1 : (p6 == '0);
            default: begin
                pat_b = 1'b0;
                pat_r = 1'b0;
            end
        endcase

        gate     = (slot < level);
        s_d.blue = pat_b & gate;
        s_d.red  = pat_r & gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign blue_o = s_q.blue;
    assign red_o  = s_q.red;

    a_r5_one_colour: assert property (@(posedge clk) disable iff (!rst_n)
        !(blue_o && red_o));

    a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (s_q.phase == '0));

    a_r4_dark_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> (!blue_o && !red_o));

    if (BAY) begin : g_bay_chk
        a_r8_no_red_in_act: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == M_ALT1) |=> !red_o);
        a_r8_dark_while_held: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == M_ALT1 && s_q.hold != '0) |=> !blue_o);
        a_r7_bay_steady: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == M_ALT7 && slot < level) |=> blue_o);
    end

endmodule

// File: rtl/bicolor_led_ctrl.sv
module bicolor_led_ctrl
    import bicolor_led_pkg::*;
#(
    parameter int NUM_BAYS  = 5,
    parameter int STEP_CLKS = 25_000_000,
    parameter int SLOT_CLKS = 6250,
    parameter int HOLD_CLKS = 2_500_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic [VAL_W-1:0]    bus_data,
    input  logic                bus_en,
    input  logic [NUM_BAYS-1:0] bay_act,
    output logic                front_blue,
    output logic                front_red,
    output logic [NUM_BAYS-1:0] bay_blue,
    output logic [NUM_BAYS-1:0] bay_red
);

    localparam int NREG = REG_BAY_BASE + NUM_BAYS;

    logic [NREG-1:0][VAL_W-1:0] regs;
    logic [NREG-1:0]            wr;
    logic                       step_tick;
    logic [SLOT_W-1:0]          slot;

    led_strobe_bus #(.AW(3), .NREG(NREG)) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_en   (bus_en),
        .regs_o   (regs),
        .wr_o     (wr)
    );

    led_timebase #(.STEP_CLKS(STEP_CLKS), .SLOT_CLKS(SLOT_CLKS)) time_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .slot_o    (slot)
    );

    led_channel #(.BAY(1'b0), .HOLD_CLKS(HOLD_CLKS)) front_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (regs[REG_FRONT_MODE]),
        .level     (regs[REG_FRONT_LVL]),
        .mode_wr   (wr[REG_FRONT_MODE]),
        .step_tick (step_tick),
        .slot      (slot),
        .act       (1'b0),
        .blue_o    (front_blue),
        .red_o     (front_red)
    );

    for (genvar k = 0; k < NUM_BAYS; k++) begin : g_bay
        led_channel #(.BAY(1'b1), .HOLD_CLKS(HOLD_CLKS)) bay_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (regs[REG_BAY_BASE + k]),
            .level     (regs[REG_BAY_LVL]),
            .mode_wr   (wr[REG_BAY_BASE + k]),
            .step_tick (step_tick),
            .slot      (slot),
            .act       (bay_act[k]),
            .blue_o    (bay_blue[k]),
            .red_o     (bay_red[k])
        );
    end

endmodule

// File: tb/bicolor_led_ctrl_tb_top.sv
module bicolor_led_ctrl_tb_top;

    localparam int STEP   = 64;
    localparam int HOLD   = 20;
    localparam int PERIOD = 12 * STEP;
    localparam int NB     = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    bus_addr;
    logic [2:0]    bus_data;
    logic          bus_en;
    logic [NB-1:0] bay_act;
    logic          front_blue, front_red;
    logic [NB-1:0] bay_blue, bay_red;

    int errs   = 0;
    int checks = 0;
    int cfb, cfr;
    int cbb [NB];
    int cbr [NB];
    bit done = 1'b0;

    always #5 clk = ~clk;

    bicolor_led_ctrl #(
        .NUM_BAYS (NB),
        .STEP_CLKS(STEP),
        .SLOT_CLKS(1),
        .HOLD_CLKS(HOLD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_en     (bus_en),
        .bay_act    (bay_act),
        .front_blue (front_blue),
        .front_red  (front_red),
        .bay_blue   (bay_blue),
        .bay_red    (bay_red)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a);
        bus_data = 3'(d);
        bus_en   = 1'b1;
        repeat (4) @(negedge clk);
        bus_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int n);
        cfb = 0;
        cfr = 0;
        for (int k = 0; k < NB; k++) begin
            cbb[k] = 0;
            cbr[k] = 0;
        end
        repeat (n) begin
            @(negedge clk);
            cfb += int'(front_blue);
            cfr += int'(front_red);
            for (int k = 0; k < NB; k++) begin
                cbb[k] += int'(bay_blue[k]);
                cbr[k] += int'(bay_red[k]);
            end
        end
    endtask

    // blue / red steps per 12-step period
    function automatic int blue_steps(input bit bay, input int m);
        case (m)
            1: return 12;
            3: return 6;
            5: return 10;
            6: return 6;
            7: return bay ? 12 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic int red_steps(input int m);
        case (m)
            2: return 12;
            4: return 6;
            5: return 2;
            6: return 6;
            default: return 0;
        endcase
    endfunction

    // lit cycles in one period: steps * STEP * level / 8
    function automatic int lit(input int steps, input int lvl);
        return steps * STEP * lvl / 8;
    endfunction

    initial begin
        rst_n    = 1'b0;
        bus_addr = '0;
        bus_data = '0;
        bus_en   = 1'b0;
        bay_act  = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state, everything dark
        measure(64);
        chk("R3 front blue after reset", cfb, 0);
        chk("R3 front red after reset", cfr, 0);
        for (int k = 0; k < NB; k++) begin
            chk($sformatf("R3 bay%0d blue after reset", k), cbb[k], 0);
            chk($sformatf("R3 bay%0d red after reset", k), cbr[k], 0);
        end

        // bays steady blue at full level, to observe isolation (R2)
        wr(2, 7);
        for (int k = 0; k < NB; k++) wr(3 + k, 7);

        // R4 R5 R6: front sweep of every mode and level
        for (int lvl = 0; lvl < 8; lvl++) begin
            wr(1, lvl);
            for (int m = 0; m < 8; m++) begin
                int bsum;
                wr(0, m);
                repeat (16) @(negedge clk);
                measure(PERIOD);
                chk($sformatf("%s/R4 front blue m=%0d lvl=%0d", (m < 5) ? "R5" : "R6", m, lvl),
                    cfb, lit(blue_steps(1'b0, m), lvl));
                chk($sformatf("%s/R4 front red m=%0d lvl=%0d", (m < 5) ? "R5" : "R6", m, lvl),
                    cfr, lit(red_steps(m), lvl));
                bsum = 0;
                for (int k = 0; k < NB; k++) bsum += cbb[k] + cbr[k];
                chk($sformatf("R2 bays unchanged by front m=%0d lvl=%0d", m, lvl),
                    bsum, NB * lit(12, 7));
            end
        end

        // R7 R8: bay sweep, front dark
        wr(0, 0);
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < NB; k++) wr(3 + k, m);
            repeat (16) @(negedge clk);
            measure(PERIOD);
            for (int k = 0; k < NB; k++) begin
                chk($sformatf("%s bay%0d blue m=%0d", (m == 1) ? "R8" : "R7", k, m),
                    cbb[k], lit(blue_steps(1'b1, m), 7));
                chk($sformatf("%s bay%0d red m=%0d", (m == 1) ? "R8" : "R7", k, m),
                    cbr[k], lit(red_steps(m), 7));
            end
            chk($sformatf("R2 front stays dark bay m=%0d", m), cfb + cfr, 0);
        end

        // R4: shared bay level (bays in steady blue)
        for (int i = 0; i < 3; i++) begin
            int lvl;
            lvl = (i == 0) ? 0 : ((i == 1) ? 3 : 5);
            wr(2, lvl);
            measure(PERIOD);
            for (int k = 0; k < NB; k++)
                chk($sformatf("R4 bay%0d level=%0d", k, lvl), cbb[k], lit(12, lvl));
        end

        // R1: distinct mode per bay reveals the address map
        wr(2, 7);
        for (int k = 0; k < NB; k++) wr(3 + k, 2 + k);
        repeat (16) @(negedge clk);
        measure(PERIOD);
        for (int k = 0; k < NB; k++) begin
            chk($sformatf("R1 bay%0d blue mode=%0d", k, 2 + k), cbb[k], lit(blue_steps(1'b1, 2 + k), 7));
            chk($sformatf("R1 bay%0d red mode=%0d", k, 2 + k), cbr[k], lit(red_steps(2 + k), 7));
        end

        // R8: activity following
        for (int k = 0; k < NB; k++) wr(3 + k, 1);
        repeat (16) @(negedge clk);
        @(negedge clk);
        bay_act[0] = 1'b1;
        @(negedge clk);
        bay_act[0] = 1'b0;
        repeat (4) @(negedge clk);
        measure(16);
        chk("R8 bay0 dark after short pulse", cbb[0], 0);
        chk("R8 bay0 red stays off", cbr[0], 0);
        chk("R8 bay1 idle stays blue", cbb[1], 14);
        repeat (20) @(negedge clk);
        measure(16);
        chk("R8 bay0 blue again after hold", cbb[0], 14);

        bay_act[2] = 1'b1;
        repeat (8) @(negedge clk);
        measure(16);
        chk("R8 bay2 dark while active", cbb[2], 0);
        bay_act[2] = 1'b0;
        repeat (4) @(negedge clk);
        measure(16);
        chk("R8 bay2 dark after long pulse", cbb[2], 0);
        chk("R8 bay3 unaffected", cbb[3], 14);

        // R9: rewriting the same mode restarts the pattern
        wr(1, 7);
        wr(0, 3);
        for (int rep = 0; rep < 2; rep++) begin
            int zrun;
            zrun = 0;
            for (int i = 0; i < 2000 && zrun < 16; i++) begin
                @(negedge clk);
                zrun = front_blue ? 0 : zrun + 1;
            end
            bus_addr = 3'd0;
            bus_data = 3'd3;
            bus_en   = 1'b1;
            repeat (8) @(negedge clk);
            measure(48);
            bus_en = 1'b0;
            chk($sformatf("R9 restart lit window rep=%0d", rep), cfb, 42);
            repeat (8) @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule